// File: doc/BRIEF.md
# Bridged Sub-Block Power Sequencer

This block brings one sub-block of an already powered domain into and out of service. The sub-block reaches memory through two asynchronous bus bridges, one on the master side and one on the slave side. Each bridge is parked or released through a stop-request output and an acknowledge input. The sequencer also drives the sub-block's clock enable and its active-low reset. Software sends on, off and reset commands as keyed 32-bit words. Each command ends in a single-cycle done pulse, or in an error pulse with a code.

Bringing the sub-block up follows a fixed order. The clock runs for a while with reset held so that the reset can propagate. The clock is then gated, reset is released, and the clock is re-enabled. Last, the bridges are released, master before slave. Taking it down runs the reverse: the slave bridge is stopped, then the master, then the clock is gated and reset is asserted. Every handshake has a cycle timeout, and a failed step undoes the steps already taken. A build option removes the bridges, and then only the clock and reset steps run.

Top module: `subdom_seq`

## Requirements
- R1: A command is taken only when `cmd_valid` is high and `cmd_word[31:24]` equals 8'h5A. The operation is `cmd_word[1:0]`: 01 on, 10 off, 11 reset, 00 nothing. Any other write leaves every output unchanged and produces no response.
- R2: On power-up, the clock enable stays high for at least PULSE_CYCLES cycles while reset is low. The clock is then gated. Reset rises while the clock enable is low, and the clock enable rises after that.
- R3: Once the clock is back on, the master stop output falls first. The slave stop output falls only after the master acknowledge reads 0. A bridge is released only while reset is high and the clock is enabled.
- R4: Any acknowledge that does not reach its target value within TIMEOUT_CYCLES cycles ends the sequence with an error pulse and code 1 (timeout).
- R5: If the slave release times out, both stop outputs return to 1 and the sequencer waits for the master acknowledge. It then gates the clock, asserts reset and reports code 1.
- R6: If the master release times out, the master stop output returns to 1, the slave is never released, the clock is gated, reset is asserted and code 1 is reported.
- R7: On power-down, the slave stop output rises before the master stop output. On success the clock is gated first, reset is asserted next, and done pulses.
- R8: If the master stop times out, the slave bridge is released again and code 1 is reported; clock and reset stay on. If the slave stop times out, the slave stop output returns to 0 and code 1 is reported; all other outputs are unchanged.
- R9: A reset command runs the full power-down and then the full power-up, and ends with a single done. When `parent_on` is low, it is refused with code 3 and nothing changes.
- R10: With HAS_BRIDGE = 0, no handshake runs, both stop outputs stay 1, and only the clock and reset steps run.
- R11: `rst_status` reads 1 exactly while `sub_rst_n` is 0.
- R12: `busy` is high while a sequence runs, and it rises only after a command. A keyed command that arrives while busy is refused with code 2, and the running sequence completes unaffected.
- R13: After reset, the clock enable and `sub_rst_n` are 0, both stop outputs are 1, and `busy`, `done` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command write strobe |
| cmd_word | input | 32 | Command word: key in [31:24], operation in [1:0] |
| parent_on | input | 1 | The parent domain is powered |
| mst_ack | input | 1 | Master bridge acknowledge (1 = stopped) |
| slv_ack | input | 1 | Slave bridge acknowledge (1 = stopped) |
| mst_stop | output | 1 | Master bridge stop request |
| slv_stop | output | 1 | Slave bridge stop request |
| sub_clk_en | output | 1 | Sub-block clock enable |
| sub_rst_n | output | 1 | Sub-block reset, active low |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Single-cycle success pulse |
| err | output | 1 | Single-cycle error pulse |
| err_code | output | 2 | Code of the last error: 1 timeout, 2 busy, 3 parent off |
| rst_status | output | 1 | 1 while the sub-block is held in reset |

## Verification
The bench builds two copies of the block. The first has bridges, PULSE_CYCLES = 5 and TIMEOUT_CYCLES = 12. A bridge model in the bench answers after two cycles, so every handshake completes well inside the timeout. Freezing one acknowledge at a chosen level then triggers each of the four timeout paths and their rollbacks within a few dozen cycles. The second copy is built with HAS_BRIDGE = 0, so the clock and reset steps can be seen with no handshake at all.

// File: rtl/subdom_pkg.sv
package subdom_pkg;

    localparam logic [7:0] WR_KEY = 8'h5A;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_ON    = 2'b01,
        OP_OFF   = 2'b10,
        OP_RESET = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        EC_NONE     = 2'd0,
        EC_TIMEOUT  = 2'd1,
        EC_BUSY     = 2'd2,
        EC_NOPARENT = 2'd3
    } err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_UP_PULSE, S_UP_GATE, S_UP_CLK, S_UP_MST, S_UP_SLV,
        S_UNDO_MST, S_DN_SLV, S_DN_MST, S_REDO_SLV, S_OFF_CLK, S_OFF_RST
    } state_e;

    typedef struct packed {
        state_e st;
        logic   fail;
        logic   again;
        logic   clk_en;
        logic   rst_n;
        logic   mst_req;
        logic   slv_req;
        logic   done;
        logic   err;
        err_e   code;
    } seq_t;

endpackage

// File: rtl/subdom_cmd_dec.sv
module subdom_cmd_dec
    import subdom_pkg::*;
(
    input  logic        cmd_valid,
    input  logic [31:0] cmd_word,
    output op_e         op
);
    logic unused_bits;
    assign unused_bits = ^cmd_word[23:2];

    always_comb begin
        if (cmd_valid && cmd_word[31:24] == WR_KEY)
            op = op_e'(cmd_word[1:0]);
        else
            op = OP_NONE;
    end
endmodule

// File: rtl/subdom_timer.sv
module subdom_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] lim,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;

    assign hit = (cnt_q >= lim);

    always_comb begin
        if (clr)      cnt_d = '0;
        else if (hit) cnt_d = cnt_q;
        else          cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/subdom_seq.sv
module subdom_seq
    import subdom_pkg::*;
#(
    parameter bit HAS_BRIDGE     = 1'b1,
    parameter int PULSE_CYCLES   = 32,
    parameter int TIMEOUT_CYCLES = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [31:0] cmd_word,
    input  logic        parent_on,
    input  logic        mst_ack,
    input  logic        slv_ack,
    output logic        mst_stop,
    output logic        slv_stop,
    output logic        sub_clk_en,
    output logic        sub_rst_n,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [1:0]  err_code,
    output logic        rst_status
);
    localparam int MAXLIM = (PULSE_CYCLES > TIMEOUT_CYCLES) ? PULSE_CYCLES : TIMEOUT_CYCLES;
    localparam int CNT_W  = $clog2(MAXLIM + 1);
    localparam state_e DN_FIRST = HAS_BRIDGE ? S_DN_SLV : S_OFF_CLK;

    seq_t       d, q;
    op_e        op;
    logic       hit, clr, ack_m, ack_s;
    logic [CNT_W-1:0] lim;

    subdom_cmd_dec u_dec (.cmd_valid(cmd_valid), .cmd_word(cmd_word), .op(op));

    generate
        if (HAS_BRIDGE) begin : g_bridge
            assign ack_m = mst_ack;
            assign ack_s = slv_ack;
        end else begin : g_nobridge
            logic unused_acks;
            assign unused_acks = mst_ack ^ slv_ack;
            assign ack_m = 1'b1;
            assign ack_s = 1'b1;
        end
    endgenerate

    assign lim = (q.st == S_UP_PULSE) ? CNT_W'(PULSE_CYCLES) : CNT_W'(TIMEOUT_CYCLES);
    assign clr = (d.st != q.st);

    subdom_timer #(.W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .lim(lim), .hit(hit)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                d.fail = 1'b0;
                unique case (op)
                    OP_ON: begin
                        d.st     = S_UP_PULSE;
                        d.clk_en = 1'b1;
                    end
                    OP_OFF: begin
                        d.st    = DN_FIRST;
                        d.again = 1'b0;
                    end
                    OP_RESET: begin
                        if (parent_on) begin
                            d.st    = DN_FIRST;
                            d.again = 1'b1;
                        end else begin
                            d.err  = 1'b1;
                            d.code = EC_NOPARENT;
                        end
                    end
                    default: ;
                endcase
            end
            S_UP_PULSE: if (hit) begin
                d.clk_en = 1'b0;
                d.st     = S_UP_GATE;
            end
            S_UP_GATE: begin
                d.rst_n = 1'b1;
                d.st    = S_UP_CLK;
            end
            S_UP_CLK: begin
                d.clk_en = 1'b1;
                if (HAS_BRIDGE) d.st = S_UP_MST;
                else begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end
            end
            S_UP_MST: begin
                d.mst_req = 1'b0;
                if (!q.mst_req && !ack_m) d.st = S_UP_SLV;
                else if (hit) begin
                    d.mst_req = 1'b1;
                    d.fail    = 1'b1;
                    d.st      = S_OFF_CLK;
                end
            end
            S_UP_SLV: begin
                d.slv_req = 1'b0;
                if (!q.slv_req && !ack_s) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end else if (hit) begin
                    d.slv_req = 1'b1;
                    d.mst_req = 1'b1;
                    d.fail    = 1'b1;
                    d.st      = S_UNDO_MST;
                end
            end
            S_UNDO_MST: if ((q.mst_req && ack_m) || hit) d.st = S_OFF_CLK;
            S_DN_SLV: begin
                d.slv_req = 1'b1;
                if (q.slv_req && ack_s) d.st = S_DN_MST;
                else if (hit) begin
                    d.slv_req = 1'b0;
                    d.st      = S_IDLE;
                    d.err     = 1'b1;
                    d.code    = EC_TIMEOUT;
                end
            end
            S_DN_MST: begin
                d.mst_req = 1'b1;
                if (q.mst_req && ack_m) d.st = S_OFF_CLK;
                else if (hit)           d.st = S_REDO_SLV;
            end
            S_REDO_SLV: begin
                d.slv_req = 1'b0;
                if ((!q.slv_req && !ack_s) || hit) begin
                    d.st   = S_IDLE;
                    d.err  = 1'b1;
                    d.code = EC_TIMEOUT;
                end
            end
            S_OFF_CLK: begin
                d.clk_en = 1'b0;
                d.st     = S_OFF_RST;
            end
            S_OFF_RST: begin
                d.rst_n = 1'b0;
                if (q.fail) begin
                    d.st   = S_IDLE;
                    d.err  = 1'b1;
                    d.code = EC_TIMEOUT;
                end else if (q.again) begin
                    d.again  = 1'b0;
                    d.clk_en = 1'b1;
                    d.st     = S_UP_PULSE;
                end else begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
        if (q.st != S_IDLE && op != OP_NONE && !d.err) begin
            d.err  = 1'b1;
            d.code = EC_BUSY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, fail: 1'b0, again: 1'b0, clk_en: 1'b0, rst_n: 1'b0,
                   mst_req: 1'b1, slv_req: 1'b1, done: 1'b0, err: 1'b0, code: EC_NONE};
        end else begin
            q <= d;
        end
    end

    assign mst_stop   = q.mst_req;
    assign slv_stop   = q.slv_req;
    assign sub_clk_en = q.clk_en;
    assign sub_rst_n  = q.rst_n;
    assign busy       = (q.st != S_IDLE);
    assign done       = q.done;
    assign err        = q.err;
    assign err_code   = q.code;
    assign rst_status = ~q.rst_n;
endmodule

// File: rtl/subdom_seq_chk.sv
module subdom_seq_chk #(
    parameter int PULSE_CYCLES = 32,
    parameter bit HAS_BRIDGE   = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic sub_clk_en,
    input logic sub_rst_n,
    input logic mst_stop,
    input logic slv_stop
);
    int hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        hi_cnt <= 0;
        else if (!sub_clk_en)              hi_cnt <= 0;
        else if (hi_cnt < PULSE_CYCLES + 4) hi_cnt <= hi_cnt + 1;
    end

    // R2
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sub_clk_en) && !sub_rst_n) |-> hi_cnt >= PULSE_CYCLES);

    // R2
    rst_rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sub_rst_n) |-> !sub_clk_en);

    // R3
    mst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mst_stop) |-> slv_stop);

    // R3
    rel_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mst_stop |-> (sub_rst_n && sub_clk_en));

    // R7
    slv_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_stop) |-> slv_stop);

    // R12
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    generate
        if (!HAS_BRIDGE) begin : g_nb
            // R10
            nobridge_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                mst_stop && slv_stop);
        end
    endgenerate
endmodule

bind subdom_seq subdom_seq_chk #(.PULSE_CYCLES(PULSE_CYCLES), .HAS_BRIDGE(HAS_BRIDGE)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy),
    .sub_clk_en(sub_clk_en), .sub_rst_n(sub_rst_n),
    .mst_stop(mst_stop), .slv_stop(slv_stop)
);

// File: tb/sim_subdom_seq.sv
module sim_subdom_seq;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 5;
    localparam int TMO        = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_valid1 = 1'b0;
    logic [31:0] cmd_word = '0;
    logic parent_on = 1'b1;
    logic m_frz = 1'b0, s_frz = 1'b0;
    logic m_p, m_ack, s_p, s_ack;
    logic mst_stop, slv_stop, sub_clk_en, sub_rst_n, busy, done, err, rst_status;
    logic [1:0] err_code;
    logic b_ms, b_ss, b_clk, b_rst, b_busy, b_done, b_err, b_rs;
    logic [1:0] b_code;

    int n_cmp = 0, n_bad = 0, cyc = 0;

    subdom_seq #(.HAS_BRIDGE(1'b1), .PULSE_CYCLES(PULSE), .TIMEOUT_CYCLES(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .parent_on(parent_on), .mst_ack(m_ack), .slv_ack(s_ack),
        .mst_stop(mst_stop), .slv_stop(slv_stop), .sub_clk_en(sub_clk_en),
        .sub_rst_n(sub_rst_n), .busy(busy), .done(done), .err(err),
        .err_code(err_code), .rst_status(rst_status));

    subdom_seq #(.HAS_BRIDGE(1'b0), .PULSE_CYCLES(PULSE), .TIMEOUT_CYCLES(TMO)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid1), .cmd_word(cmd_word),
        .parent_on(parent_on), .mst_ack(1'b0), .slv_ack(1'b0),
        .mst_stop(b_ms), .slv_stop(b_ss), .sub_clk_en(b_clk),
        .sub_rst_n(b_rst), .busy(b_busy), .done(b_done), .err(b_err),
        .err_code(b_code), .rst_status(b_rs));

    always #(CLK_PERIOD/2) clk = ~clk;

    // bridge model: acknowledge follows stop request after two cycles unless frozen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_p <= 1'b1; m_ack <= 1'b1; s_p <= 1'b1; s_ack <= 1'b1;
        end else begin
            m_p <= mst_stop;
            s_p <= slv_stop;
            if (!m_frz) m_ack <= m_p;
            if (!s_frz) s_ack <= s_p;
        end
    end

    typedef struct { bit is_err; int code; string req; } exp_t;
    exp_t exq[$];

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // event trackers and scoreboard monitor
    logic p_clk = 0, p_rst = 0, p_ms = 1, p_ss = 1;
    int run = 0, last_pulse = 0;
    int t_clk_fall = 0, t_rst_rise = 0, t_rst_fall = 0, t_mst_rel = 0, t_slv_rel = 0;
    int t_mst_stop = 0, t_slv_stop = 0, t_err = 0;
    int u1_done = 0;
    bit u1_bad = 0, busy_seen = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sub_clk_en && !sub_rst_n) run++;
            if (p_clk && !sub_clk_en) begin t_clk_fall = cyc; last_pulse = run; end
            if (!sub_clk_en) run = 0;
            if (!p_rst && sub_rst_n) t_rst_rise = cyc;
            if (p_rst && !sub_rst_n) t_rst_fall = cyc;
            if (p_ms && !mst_stop) t_mst_rel = cyc;
            if (p_ss && !slv_stop) t_slv_rel = cyc;
            if (!p_ms && mst_stop) t_mst_stop = cyc;
            if (!p_ss && slv_stop) t_slv_stop = cyc;
            p_clk = sub_clk_en; p_rst = sub_rst_n; p_ms = mst_stop; p_ss = slv_stop;
            if (busy) busy_seen = 1;
            if (!b_ms || !b_ss) u1_bad = 1;
            if (b_done) u1_done++;
            if (err) t_err = cyc;
            if (done || err) begin
                if (exq.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R12 unexpected response: actual err=%0d code=%0d expected none",
                             err, err_code);
                end else begin
                    exp_t e;
                    e = exq.pop_front();
                    chk(e.req, "response kind err", int'(err), int'(e.is_err));
                    if (e.is_err) chk(e.req, "error code", int'(err_code), e.code);
                end
            end
        end
    end

    task automatic expect_rsp(bit is_err, int code, string req);
        exp_t e;
        e.is_err = is_err; e.code = code; e.req = req;
        exq.push_back(e);
    endtask

    task automatic issue(logic [31:0] w);
        @(negedge clk);
        cmd_word  = w;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (exq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_state(string req, int ce, int rn, int ms, int ss);
        chk(req, "sub_clk_en", int'(sub_clk_en), ce);
        chk(req, "sub_rst_n", int'(sub_rst_n), rn);
        chk(req, "mst_stop", int'(mst_stop), ms);
        chk(req, "slv_stop", int'(slv_stop), ss);
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    localparam logic [31:0] C_ON  = 32'h5A00_0001;
    localparam logic [31:0] C_OFF = 32'h5A00_0002;
    localparam logic [31:0] C_RST = 32'h5A00_0003;

    initial begin
        repeat (100000) @(negedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_up();
    end

    initial begin
        int start;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state, R11 status
        chk_state("R13", 0, 0, 1, 1);
        chk("R13", "busy", int'(busy), 0);
        chk("R13", "done|err", int'(done | err), 0);
        chk("R11", "rst_status in reset", int'(rst_status), 1);

        // R1 unkeyed writes ignored
        busy_seen = 0;
        issue(32'h0000_0001);
        issue(32'hA500_0001);
        issue(32'h5A00_0000);
        repeat (10) @(negedge clk);
        chk("R1", "busy seen", int'(busy_seen), 0);
        chk_state("R1", 0, 0, 1, 1);

        // R2 R3 power-up
        expect_rsp(0, 0, "R2");
        issue(C_ON);
        drain();
        chk_state("R3", 1, 1, 0, 0);
        chk("R11", "rst_status out of reset", int'(rst_status), 0);
        chk("R2", "pulse length ok", int'(last_pulse >= PULSE), 1);
        chk("R2", "reset rises after clock gate", int'(t_rst_rise > t_clk_fall), 1);
        chk("R3", "master released after reset", int'(t_mst_rel > t_rst_rise), 1);
        chk("R3", "slave after master", int'(t_slv_rel > t_mst_rel), 1);

        // R12 busy reject during power-down, R7 ordering
        expect_rsp(1, 2, "R12");
        expect_rsp(0, 0, "R7");
        issue(C_OFF);
        issue(C_ON);
        drain();
        chk_state("R7", 0, 0, 1, 1);
        chk("R7", "slave stopped before master", int'(t_slv_stop < t_mst_stop), 1);
        chk("R7", "clock gated before reset", int'(t_clk_fall < t_rst_fall), 1);

        // R9 reset refused when parent off
        parent_on = 1'b0;
        expect_rsp(1, 3, "R9");
        issue(C_RST);
        drain();
        chk_state("R9", 0, 0, 1, 1);
        parent_on = 1'b1;

        // R9 reset = down then up
        expect_rsp(0, 0, "R9");
        issue(C_ON);
        drain();
        start = cyc;
        expect_rsp(0, 0, "R9");
        issue(C_RST);
        drain();
        chk_state("R9", 1, 1, 0, 0);
        chk("R9", "slave stop then master stop", int'(t_slv_stop > start && t_mst_stop > t_slv_stop), 1);
        chk("R9", "reset pulsed", int'(t_rst_fall > start && t_rst_rise > t_rst_fall), 1);

        // R8 master stop timeout
        m_frz = 1'b1;
        expect_rsp(1, 1, "R8");
        issue(C_OFF);
        drain();
        chk_state("R8", 1, 1, 1, 0);
        m_frz = 1'b0;
        repeat (4) @(negedge clk);
        expect_rsp(0, 0, "R7");
        issue(C_OFF);
        drain();
        chk_state("R7", 0, 0, 1, 1);

        // R6 R4 master release timeout
        m_frz = 1'b1;
        expect_rsp(1, 1, "R6");
        issue(C_ON);
        drain();
        chk_state("R6", 0, 0, 1, 1);
        chk("R4", "timeout window", int'((t_err - t_mst_rel) >= TMO && (t_err - t_mst_rel) <= TMO + 6), 1);
        m_frz = 1'b0;
        repeat (4) @(negedge clk);

        // R5 slave release timeout
        s_frz = 1'b1;
        start = cyc;
        expect_rsp(1, 1, "R5");
        issue(C_ON);
        drain();
        chk_state("R5", 0, 0, 1, 1);
        chk("R5", "master was released", int'(t_mst_rel > start), 1);
        s_frz = 1'b0;
        repeat (4) @(negedge clk);

        // R8 slave stop timeout
        expect_rsp(0, 0, "R8");
        issue(C_ON);
        drain();
        s_frz = 1'b1;
        expect_rsp(1, 1, "R8");
        issue(C_OFF);
        drain();
        chk_state("R8", 1, 1, 0, 0);
        s_frz = 1'b0;
        repeat (4) @(negedge clk);

        // R10 no-bridge build
        @(negedge clk);
        cmd_word = C_ON;
        cmd_valid1 = 1'b1;
        @(negedge clk);
        cmd_valid1 = 1'b0;
        repeat (30) @(negedge clk);
        chk("R10", "done count", u1_done, 1);
        chk("R10", "clock on", int'(b_clk), 1);
        chk("R10", "reset released", int'(b_rst), 1);
        chk("R10", "stops stayed high", int'(u1_bad), 0);

        finish_up();
    end
endmodule